// File: doc/BRIEF.md
# Packed Rounding Shift and Narrowing Unit

This unit performs lane-wise right shifts on packed 32-bit data. Four operations are selected per request: an arithmetic right shift of four signed bytes, a logical right shift of two unsigned halfwords, and a narrowing shift. The narrowing shift moves two signed 32-bit words right and packs the low 16 bits of each into one word. A fourth operation is a Q31 fractional multiply, which has a dedicated path for the one product that cannot be represented. The arithmetic shifts and the multiply can round to nearest. For the shifts, rounding adds the last bit shifted out back into the shifted lane.

A request is a single-cycle `in_valid` strobe with the operands, a shift amount, an operation code and a round enable. A small two-state controller tracks the output register. In `ST_IDLE` the output is not valid. A strobe takes the transition `GO_DONE` to `ST_DONE`, which shows the registered result for exactly one cycle. From `ST_DONE`, a new strobe takes `STAY_DONE` and no strobe takes `BACK_IDLE`. With no strobe in `ST_IDLE`, the controller takes `STAY_IDLE`. The result and flag hold their values between requests.

Top module: `rsn_shift_unit`

## Requirements
- R1: With `op` = 0, each byte lane `src_a[8i+7:8i]` is shifted right arithmetically by `shamt[2:0]`, the result keeps 8 bits per lane, and `shamt[4:3]` has no effect.
- R2: For the arithmetic shifts (`op` 0 and 2), when `round_en` is 1 and the shift amount is nonzero, the result is the shifted lane plus bit (shift−1) of the unshifted lane. The increment wraps within the lane width.
- R3: An arithmetic shift by zero returns the lane unchanged for either value of `round_en`.
- R4: With `op` = 1, each 16-bit lane of `src_a` is shifted right logically by `shamt[3:0]`, and `round_en` and `shamt[4]` have no effect.
- R5: With `op` = 2, `src_a` and `src_b` are each shifted arithmetically by `shamt[4:0]`. The low 16 bits of the shifted `src_a` form `result[31:16]`, and the low 16 bits of the shifted `src_b` form `result[15:0]`.
- R6: With `op` = 3 and both operands equal to 0x80000000, the result is 0x7FFFFFFF and `sat_flag` is 1.
- R7: With `op` = 3 and any other operands, the result is bits [63:32] of twice the signed 64-bit product, plus 0x80000000 before the selection when `round_en` is 1. `sat_flag` is 0 for this case and for every `op` other than 3.
- R8: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high. `result` and `sat_flag` for that request appear in the same cycle.
- R9: While `in_valid` is low, `result` and `sat_flag` keep their previous values.
- R10: During and right after reset, `out_valid`, `result` and `sat_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Operation: 0 byte shift, 1 halfword shift, 2 narrowing, 3 Q31 multiply |
| round_en | input | 1 | Round-to-nearest enable |
| shamt | input | 5 | Shift amount (low bits used per operation) |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand (narrowing low half, multiplier) |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Registered result |
| sat_flag | output | 1 | Registered multiply saturation flag |

## Verification
Every result and the saturation flag are due exactly one clock edge after the strobe. `out_valid` rises at that same edge and falls one edge later unless another strobe follows. The bench drives inputs on the falling edge. Its reference model updates at each rising edge from the inputs presented there. The outputs are compared against the model on the next falling edge, so each comparison sees the state after exactly one register stage. The gaps between requests are used to confirm that the held result and flag do not move.

// File: rtl/rsn_pkg.sv
package rsn_pkg;
    localparam int RSN_DATA_W  = 32;
    localparam int RSN_BYTE_W  = 8;
    localparam int RSN_HALF_W  = 16;
    localparam int RSN_SHAMT_W = 5;

    typedef enum logic [1:0] {
        OP_BYTE_SRA  = 2'd0,
        OP_HALF_SRL  = 2'd1,
        OP_NARROW    = 2'd2,
        OP_Q31_MUL   = 2'd3
    } rsn_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } rsn_state_e;
endpackage

// File: rtl/rsn_round_shift.sv
module rsn_round_shift #(
    parameter int W    = 8,
    parameter int SH_W = 3
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] sh,
    input  logic            rnd,
    output logic [W-1:0]    dout
);
    logic [W-1:0] shifted;
    logic [W-1:0] probe;
    logic         rbit;

    always_comb begin
        shifted = W'($signed(din) >>> sh);
        probe   = din >> (sh - SH_W'(1));
        rbit    = rnd && (sh != '0) && probe[0];
        // increment wraps inside the lane, no saturation
        dout    = shifted + W'(rbit);
    end
endmodule

// File: rtl/rsn_logic_shift.sv
module rsn_logic_shift #(
    parameter int W    = 16,
    parameter int SH_W = 4
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] sh,
    output logic [W-1:0]    dout
);
    always_comb dout = din >> sh;
endmodule

// File: rtl/rsn_q31_mul.sv
module rsn_q31_mul #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         rnd,
    output logic [W-1:0] prod_hi,
    output logic         sat
);
    localparam int PW = 2 * W;
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

    logic signed [PW-1:0] ea, eb, full, dbl, acc;
    logic        [PW-1:0] half_lsb;

    always_comb begin
        ea       = {{W{a[W-1]}}, a};
        eb       = {{W{b[W-1]}}, b};
        full     = ea * eb;
        dbl      = full <<< 1;
        half_lsb = PW'(rnd) << (W - 1);
        acc      = dbl + $signed(half_lsb);
        sat      = (a == MIN_NEG) && (b == MIN_NEG);
        prod_hi  = sat ? MAX_POS : acc[PW-1:W];
    end
endmodule

// File: rtl/rsn_shift_unit.sv
module rsn_shift_unit
    import rsn_pkg::*;
#(
    parameter int DATA_W  = RSN_DATA_W,
    parameter int BYTE_W  = RSN_BYTE_W,
    parameter int HALF_W  = RSN_HALF_W,
    parameter int SHAMT_W = RSN_SHAMT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic              round_en,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              sat_flag
);
    localparam int BYTE_LANES = DATA_W / BYTE_W;
    localparam int HALF_LANES = DATA_W / HALF_W;
    localparam int BSH_W      = $clog2(BYTE_W);
    localparam int HSH_W      = $clog2(HALF_W);
    localparam int WSH_W      = $clog2(DATA_W);

    logic [DATA_W-1:0] byte_res, half_res, narrow_res, mul_res;
    logic [DATA_W-1:0] word_a_sh, word_b_sh;
    logic              mul_sat;

    // byte lanes: arithmetic shift with rounding
    genvar gi;
    generate
        for (gi = 0; gi < BYTE_LANES; gi++) begin : g_byte
            rsn_round_shift #(.W(BYTE_W), .SH_W(BSH_W)) u_bsh (
                .din  (src_a[gi*BYTE_W +: BYTE_W]),
                .sh   (shamt[BSH_W-1:0]),
                .rnd  (round_en),
                .dout (byte_res[gi*BYTE_W +: BYTE_W])
            );
        end
        for (gi = 0; gi < HALF_LANES; gi++) begin : g_half
            rsn_logic_shift #(.W(HALF_W), .SH_W(HSH_W)) u_hsh (
                .din  (src_a[gi*HALF_W +: HALF_W]),
                .sh   (shamt[HSH_W-1:0]),
                .dout (half_res[gi*HALF_W +: HALF_W])
            );
        end
    endgenerate

    rsn_round_shift #(.W(DATA_W), .SH_W(WSH_W)) u_word_a (
        .din (src_a), .sh (shamt[WSH_W-1:0]), .rnd (round_en), .dout (word_a_sh)
    );
    rsn_round_shift #(.W(DATA_W), .SH_W(WSH_W)) u_word_b (
        .din (src_b), .sh (shamt[WSH_W-1:0]), .rnd (round_en), .dout (word_b_sh)
    );

    always_comb narrow_res = {word_a_sh[DATA_W/2-1:0], word_b_sh[DATA_W/2-1:0]};

    rsn_q31_mul #(.W(DATA_W)) u_mul (
        .a (src_a), .b (src_b), .rnd (round_en), .prod_hi (mul_res), .sat (mul_sat)
    );

    // result select
    logic [DATA_W-1:0] nxt_res;
    logic              nxt_sat;

    always_comb begin
        nxt_res = '0;
        nxt_sat = 1'b0;
        unique case (rsn_op_e'(op))
            OP_BYTE_SRA: nxt_res = byte_res;
            OP_HALF_SRL: nxt_res = half_res;
            OP_NARROW:   nxt_res = narrow_res;
            OP_Q31_MUL: begin
                nxt_res = mul_res;
                nxt_sat = mul_sat;
            end
            default: nxt_res = '0;
        endcase
    end

    // controller: state register
    rsn_state_e state, state_nxt;

    always_comb begin
        state_nxt = ST_IDLE;
        unique case (state)
            ST_IDLE: state_nxt = in_valid ? ST_DONE : ST_IDLE; // GO_DONE / STAY_IDLE
            ST_DONE: state_nxt = in_valid ? ST_DONE : ST_IDLE; // STAY_DONE / BACK_IDLE
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            sat_flag <= 1'b0;
        end else if (in_valid) begin
            result   <= nxt_res;
            sat_flag <= nxt_sat;
        end
    end

    always_comb out_valid = (state == ST_DONE);

    // assertions
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(sat_flag)));
    p_zero_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd0 && shamt[BSH_W-1:0] == '0) |=> (result == $past(src_a)));
    p_mul_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd3 && src_a == {1'b1, {(DATA_W-1){1'b0}}}
                  && src_b == {1'b1, {(DATA_W-1){1'b0}}})
        |=> (sat_flag && result == {1'b0, {(DATA_W-1){1'b1}}}));
    p_flag_only_mul_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 2'd3) |=> !sat_flag);
endmodule

// File: tb/test_rsn_shift_unit.sv
`timescale 1ns/1ps
module test_rsn_shift_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        round_en = 1'b0;
    logic [4:0]  shamt = 5'd0;
    logic [31:0] src_a = 32'd0;
    logic [31:0] src_b = 32'd0;
    logic        out_valid;
    logic [31:0] result;
    logic        sat_flag;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rsn_shift_unit i_rsn_shift_unit (
        .clk, .rst_n, .in_valid, .op, .round_en, .shamt,
        .src_a, .src_b, .out_valid, .result, .sat_flag
    );

    // reference functions
    function automatic logic [31:0] ref_bytes(logic [31:0] a, int sh, bit rnd);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            int v = $signed(a[8*i +: 8]);
            int s = v >>> sh;
            if (rnd && sh != 0 && (((v >>> (sh - 1)) & 1) == 1)) s = s + 1;
            r[8*i +: 8] = s[7:0];
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_halves(logic [31:0] a, int sh);
        logic [31:0] r;
        r[15:0]  = a[15:0] >> sh;
        r[31:16] = a[31:16] >> sh;
        return r;
    endfunction

    function automatic logic [15:0] ref_word(logic [31:0] a, int sh, bit rnd);
        longint v = $signed(a);
        longint s = v >>> sh;
        if (rnd && sh != 0 && (((v >>> (sh - 1)) & 1) == 1)) s = s + 1;
        return s[15:0];
    endfunction

    function automatic logic [31:0] ref_mul(logic [31:0] a, logic [31:0] b, bit rnd);
        longint p = longint'($signed(a)) * longint'($signed(b));
        p = p <<< 1;
        if (rnd) p = p + 64'sh80000000;
        p = p >>> 32;
        return p[31:0];
    endfunction

    // behavioural reference model
    bit          m_valid = 1'b0;
    logic [31:0] m_res = '0;
    bit          m_sat = 1'b0;
    string       m_tag = "R10";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 1'b0; m_res = '0; m_sat = 1'b0; m_tag = "R10";
        end else begin
            m_valid = in_valid;
            if (in_valid) begin
                m_sat = 1'b0;
                case (op)
                    2'd0: begin
                        m_res = ref_bytes(src_a, int'(shamt[2:0]), round_en);
                        if (shamt[2:0] == 0) m_tag = "R3";
                        else if (round_en)   m_tag = "R2";
                        else                 m_tag = "R1";
                    end
                    2'd1: begin
                        m_res = ref_halves(src_a, int'(shamt[3:0]));
                        m_tag = "R4";
                    end
                    2'd2: begin
                        m_res = {ref_word(src_a, int'(shamt), round_en),
                                 ref_word(src_b, int'(shamt), round_en)};
                        m_tag = (round_en && shamt != 0) ? "R2" : "R5";
                    end
                    default: begin
                        if (src_a == 32'h8000_0000 && src_b == 32'h8000_0000) begin
                            m_res = 32'h7FFF_FFFF; m_sat = 1'b1; m_tag = "R6";
                        end else begin
                            m_res = ref_mul(src_a, src_b, round_en); m_tag = "R7";
                        end
                    end
                endcase
            end else begin
                m_tag = "R9";
            end
        end
    end

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        cycles++;
        if (!done) begin
            check("R8", "out_valid", 32'(out_valid), 32'(m_valid));
            check(m_tag, "result", result, m_res);
            check(m_tag, "sat_flag", 32'(sat_flag), 32'(m_sat));
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
            finish_run();
        end
    end

    task automatic issue(logic [1:0] o, bit r, logic [4:0] s, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        in_valid = 1'b1; op = o; round_en = r; shamt = s; src_a = a; src_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values (also compared every cycle during reset)
        check("R10", "reset result", result, 32'h0);
        check("R10", "reset valid", 32'(out_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "post reset flag", 32'(sat_flag), 32'h0);

        // R1: plain byte shift, upper shamt bits ignored
        issue(2'd0, 1'b0, 5'b11_011, 32'h80_7F_F0_0F, 32'h0);
        // R2: byte rounding with wrap of +1 at lane top
        issue(2'd0, 1'b1, 5'd1, 32'hFF_7F_03_01, 32'h0);
        issue(2'd0, 1'b1, 5'd7, 32'h40_C0_7F_80, 32'h0);
        // R3: zero shift with rounding enabled
        issue(2'd0, 1'b1, 5'b11_000, 32'hDEAD_BEEF, 32'h0);
        // R4: halfword logical, rounding ignored
        issue(2'd1, 1'b1, 5'b1_1111, 32'h8001_FFFF, 32'h0);
        issue(2'd1, 1'b0, 5'd4, 32'hF00F_1234, 32'h0);
        // R5: narrowing
        issue(2'd2, 1'b0, 5'd8, 32'h1234_5678, 32'hF000_00FF);
        issue(2'd2, 1'b1, 5'd16, 32'h0001_8000, 32'hFFFF_7FFF);
        issue(2'd2, 1'b1, 5'd0, 32'hCAFE_BABE, 32'h1357_9BDF);
        issue(2'd2, 1'b1, 5'd31, 32'h4000_0000, 32'hC000_0000);
        // R6: saturating multiply
        issue(2'd3, 1'b1, 5'd0, 32'h8000_0000, 32'h8000_0000);
        // R7: general multiply, with and without rounding
        issue(2'd3, 1'b0, 5'd0, 32'h4000_0000, 32'h4000_0000);
        issue(2'd3, 1'b1, 5'd0, 32'h8000_0000, 32'h7FFF_FFFF);
        issue(2'd3, 1'b1, 5'd0, 32'h0000_0001, 32'h4000_0000);
        issue(2'd3, 1'b0, 5'd0, 32'h8000_0000, 32'h8000_0001);
        // R9: idle gap after saturation keeps flag
        issue(2'd3, 1'b0, 5'd0, 32'h8000_0000, 32'h8000_0000);
        repeat (4) @(negedge clk);

        // back-to-back and random traffic
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            in_valid = ($urandom_range(0, 3) != 0);
            op       = 2'($urandom_range(0, 3));
            round_en = 1'($urandom_range(0, 1));
            shamt    = 5'($urandom_range(0, 31));
            src_a    = $urandom();
            src_b    = $urandom();
            if ($urandom_range(0, 15) == 0) begin
                src_a = 32'h8000_0000;
                src_b = 32'h8000_0000;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule